// File: doc/BRIEF.md
# Arithmetic Operator With Flags

This unit holds two operand registers, X and Y, and presents a result formed from them by one of four functions: a modular sum, bitwise AND, bitwise XOR or bitwise OR. A 2-bit function code kept in a small status register chooses the function. Two status flags, a carry flag and a signed-overflow flag, are kept up to date at all times. Both flags are always derived from the sum X+Y, even while a logic function drives the result.

A surrounding datapath writes X and Y through their own strobes. It loads a new function code with a dedicated command, or rewrites the status register as a whole. It reads the result and the status word through plain read ports. It asks flag questions through a skip-test port.

A build parameter removes the unit. In that variant every read port returns zero. Every write, command or query raises an illegal-operator indication and changes no state. All interfaces are single-cycle strobes with no back-pressure, because a register write or a command always completes in the cycle it is presented.

Top module: `ao_unit`

## Requirements
- R1: With function code 0 the result equals (X + Y) modulo 2^W, visible in the cycle after the operand write edge.
- R2: Function code 1 gives X AND Y, code 2 gives X XOR Y, and code 3 gives X OR Y.
- R3: The carry flag (status bit 0) equals the carry out of the top bit of X + Y. It updates on the clock edge after the edge that changed X or Y, whatever function code is selected.
- R4: The overflow flag (status bit 1) is set when X and Y share a sign and the sign of their sum differs from the sign of X. It follows the same one-edge lag as carry and is computed under every function code.
- R5: With the query strobe high, skip_hit is 1 when query bit 1 and carry are both set, or when query bit 2 and overflow are both set. Query bit 0 has no effect, and skip_hit is 0 while the strobe is low.
- R6: A function-load command stores fn_code. A status write stores data bits 3:2 as the function code, and the flag bits of that word are ignored. When both arrive in the same cycle, the function-load command wins.
- R7: Reset clears X, Y, the function code and both flags, so the result and the status word read zero.
- R8: The status word reads carry in bit 0, overflow in bit 1, the function code in bits 3:2, and zero in all higher bits.
- R9: With PRESENT=0 the result, status word and skip_hit read zero. illegal_op is high in any cycle that carries an X or Y write, a function load, a status write or a query, and such a cycle leaves every read port at zero. With PRESENT=1, illegal_op stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_wr | input | 1 | Write strobe for operand X |
| x_data | input | W | New value for X |
| y_wr | input | 1 | Write strobe for operand Y |
| y_data | input | W | New value for Y |
| fn_load | input | 1 | Function-load command |
| fn_code | input | 2 | Function code carried by the command |
| stat_wr | input | 1 | Status register write strobe |
| stat_data | input | SW | Status word to write (bits 3:2 used) |
| sk_req | input | 1 | Skip query strobe |
| sk_query | input | 3 | Query bits (bit 1 carry, bit 2 overflow) |
| result | output | W | Selected function of X and Y |
| stat_out | output | SW | Status word read port |
| skip_hit | output | 1 | Answer to the skip query |
| illegal_op | output | 1 | Access to an absent unit |

## Verification
The bench builds two instances side by side. One is a 16-bit unit with PRESENT=1, where the corner sums can be reached: 0xFFFF+1 gives carry without overflow, 0x7FFF+1 gives overflow without carry, and 0x8000+0x8000 gives both. With this instance the bench also checks that the flags keep tracking the sum while a logic function drives the result. The other is an 8-bit unit with PRESENT=0, which exercises the absent variant. On that instance every strobe must raise illegal_op and every read port must stay at zero.

// File: rtl/ao_pkg.sv
package ao_pkg;
  typedef enum logic [1:0] {
    AO_FN_ADD = 2'd0,
    AO_FN_AND = 2'd1,
    AO_FN_XOR = 2'd2,
    AO_FN_OR  = 2'd3
  } ao_fn_e;

  localparam int ST_CRY   = 0;
  localparam int ST_OVF   = 1;
  localparam int ST_FN_LO = 2;
  localparam int ST_USED  = 4;

  localparam int QRY_CRY = 1;
  localparam int QRY_OVF = 2;
endpackage

// File: rtl/ao_operand_regs.sv
module ao_operand_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         x_wr,
  input  logic [W-1:0] x_data,
  input  logic         y_wr,
  input  logic [W-1:0] y_data,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (en) begin
      if (x_wr) x_q <= x_data;
      if (y_wr) y_q <= y_data;
    end
  end
endmodule

// File: rtl/ao_func_unit.sv
module ao_func_unit
  import ao_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  ao_fn_e       fn,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W:0] sum_ext;

  assign sum_ext = {1'b0, x} + {1'b0, y};
  assign carry   = sum_ext[W];
  assign ovf     = (x[MSB] == y[MSB]) && (sum_ext[MSB] != x[MSB]);

  always_comb begin
    unique case (fn)
      AO_FN_ADD: res = sum_ext[W-1:0];
      AO_FN_AND: res = x & y;
      AO_FN_XOR: res = x ^ y;
      AO_FN_OR:  res = x | y;
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/ao_status.sv
module ao_status
  import ao_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fn_load,
  input  logic [1:0]    fn_code,
  input  logic          stat_wr,
  input  logic [SW-1:0] stat_data,
  input  logic          carry_nx,
  input  logic          ovf_nx,
  output ao_fn_e        fn_q,
  output logic          cry_q,
  output logic          ovf_q
);
  logic unused_stat;
  assign unused_stat = ^{stat_data[SW-1:ST_USED], stat_data[ST_OVF:ST_CRY]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q  <= AO_FN_ADD;
      cry_q <= 1'b0;
      ovf_q <= 1'b0;
    end else if (en) begin
      if (fn_load)      fn_q <= ao_fn_e'(fn_code);
      else if (stat_wr) fn_q <= ao_fn_e'(stat_data[ST_FN_LO +: 2]);
      cry_q <= carry_nx;
      ovf_q <= ovf_nx;
    end
  end
endmodule

// File: rtl/ao_unit.sv
module ao_unit
  import ao_pkg::*;
#(
  parameter int W       = 16,
  parameter int SW      = 16,
  parameter bit PRESENT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_wr,
  input  logic [W-1:0]  x_data,
  input  logic          y_wr,
  input  logic [W-1:0]  y_data,
  input  logic          fn_load,
  input  logic [1:0]    fn_code,
  input  logic          stat_wr,
  input  logic [SW-1:0] stat_data,
  input  logic          sk_req,
  input  logic [2:0]    sk_query,
  output logic [W-1:0]  result,
  output logic [SW-1:0] stat_out,
  output logic          skip_hit,
  output logic          illegal_op
);
  localparam int PAD_W = SW - ST_USED;

  logic [W-1:0] x_q, y_q;
  logic [W-1:0] res_raw;
  logic         carry_nx, ovf_nx;
  ao_fn_e       fn_q;
  logic         cry_q, ovf_q;
  logic         any_access;

  assign any_access = x_wr | y_wr | fn_load | stat_wr | sk_req;

  ao_operand_regs #(.W(W)) u_ops (
    .clk(clk), .rst_n(rst_n), .en(PRESENT),
    .x_wr(x_wr), .x_data(x_data), .y_wr(y_wr), .y_data(y_data),
    .x_q(x_q), .y_q(y_q)
  );

  ao_func_unit #(.W(W)) u_fn (
    .x(x_q), .y(y_q), .fn(fn_q),
    .res(res_raw), .carry(carry_nx), .ovf(ovf_nx)
  );

  ao_status #(.SW(SW)) u_st (
    .clk(clk), .rst_n(rst_n), .en(PRESENT),
    .fn_load(fn_load), .fn_code(fn_code),
    .stat_wr(stat_wr), .stat_data(stat_data),
    .carry_nx(carry_nx), .ovf_nx(ovf_nx),
    .fn_q(fn_q), .cry_q(cry_q), .ovf_q(ovf_q)
  );

  generate
    if (PRESENT) begin : g_present
      logic unused_q0;
      assign unused_q0  = sk_query[0] | any_access;
      assign result     = res_raw;
      assign stat_out   = {{PAD_W{1'b0}}, fn_q, ovf_q, cry_q};
      assign skip_hit   = sk_req & ((sk_query[QRY_CRY] & cry_q) |
                                    (sk_query[QRY_OVF] & ovf_q));
      assign illegal_op = 1'b0;
    end else begin : g_absent
      logic unused_abs;
      assign unused_abs = ^{res_raw, fn_q, cry_q, ovf_q, sk_query};
      assign result     = '0;
      assign stat_out   = '0;
      assign skip_hit   = 1'b0;
      assign illegal_op = any_access;
    end
  endgenerate
endmodule

// File: rtl/ao_unit_chk.sv
module ao_unit_chk #(
  parameter int W       = 16,
  parameter int SW      = 16,
  parameter bit PRESENT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  x_q,
  input logic [W-1:0]  y_q,
  input logic          x_wr,
  input logic [W-1:0]  result,
  input logic [SW-1:0] stat_out,
  input logic          skip_hit,
  input logic          sk_req,
  input logic          illegal_op
);
  logic [W:0] chk_sum;
  logic       chk_ovf;
  assign chk_sum = {1'b0, x_q} + {1'b0, y_q};
  assign chk_ovf = (x_q[W-1] == y_q[W-1]) && (chk_sum[W-1] != x_q[W-1]);

  generate
    if (PRESENT) begin : g_p
      p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stat_out[0] == $past(chk_sum[W]));
      p_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stat_out[1] == $past(chk_ovf));
      p_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_out[3:2] == 2'd0) |-> result == chk_sum[W-1:0]);
      p_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_out[3:2] == 2'd1) |-> result == (x_q & y_q));
      p_skip_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sk_req |-> !skip_hit);
      p_x_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !x_wr |=> $stable(x_q));
      p_no_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal_op);
    end else begin : g_a
      p_absent_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        result == '0 && stat_out == '0 && !skip_hit);
    end
  endgenerate
endmodule

bind ao_unit ao_unit_chk #(.W(W), .SW(SW), .PRESENT(PRESENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .x_q(x_q), .y_q(y_q), .x_wr(x_wr),
  .result(result), .stat_out(stat_out), .skip_hit(skip_hit),
  .sk_req(sk_req), .illegal_op(illegal_op)
);

// File: tb/test_ao_unit.sv
`timescale 1ns/1ps
module test_ao_unit;
  localparam int W  = 16;
  localparam int WA = 8;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          x_wr = 0, y_wr = 0, fn_load = 0, stat_wr = 0, sk_req = 0;
  logic [W-1:0]  x_data = '0, y_data = '0;
  logic [1:0]    fn_code = '0;
  logic [SW-1:0] stat_data = '0;
  logic [2:0]    sk_query = '0;

  logic [W-1:0]  result;
  logic [SW-1:0] stat_out;
  logic          skip_hit, illegal_op;
  logic [WA-1:0] a_result;
  logic [SW-1:0] a_stat;
  logic          a_skip, a_illegal;

  ao_unit #(.W(W), .SW(SW), .PRESENT(1'b1)) i_ao_unit (
    .clk(clk), .rst_n(rst_n), .x_wr(x_wr), .x_data(x_data), .y_wr(y_wr),
    .y_data(y_data), .fn_load(fn_load), .fn_code(fn_code), .stat_wr(stat_wr),
    .stat_data(stat_data), .sk_req(sk_req), .sk_query(sk_query),
    .result(result), .stat_out(stat_out), .skip_hit(skip_hit),
    .illegal_op(illegal_op)
  );

  ao_unit #(.W(WA), .SW(SW), .PRESENT(1'b0)) i_ao_unit_absent (
    .clk(clk), .rst_n(rst_n), .x_wr(x_wr), .x_data(x_data[WA-1:0]), .y_wr(y_wr),
    .y_data(y_data[WA-1:0]), .fn_load(fn_load), .fn_code(fn_code),
    .stat_wr(stat_wr), .stat_data(stat_data), .sk_req(sk_req),
    .sk_query(sk_query), .result(a_result), .stat_out(a_stat),
    .skip_hit(a_skip), .illegal_op(a_illegal)
  );

  int nchk = 0;
  int nbad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write_xy(input logic [W-1:0] xv, input logic [W-1:0] yv);
    x_wr = 1; y_wr = 1; x_data = xv; y_data = yv;
    step();
    x_wr = 0; y_wr = 0;
  endtask

  task automatic load_fn(input logic [1:0] c);
    fn_load = 1; fn_code = c;
    step();
    fn_load = 0;
  endtask

  function automatic logic [SW-1:0] exp_stat(input logic [W-1:0] xv,
      input logic [W-1:0] yv, input logic [1:0] c);
    logic [W:0] s;
    logic       o;
    s = {1'b0, xv} + {1'b0, yv};
    o = (xv[W-1] == yv[W-1]) && (s[W-1] != xv[W-1]);
    return {{(SW-4){1'b0}}, c, o, s[W]};
  endfunction

  task automatic t_reset();
    check("R7 result after reset", 32'(result), 32'h0);
    check("R7 status after reset", 32'(stat_out), 32'h0);
  endtask

  task automatic t_add();
    write_xy(16'hFFFF, 16'h0001);
    check("R1 wrap sum", 32'(result), 32'h0000);
    check("R3 flags lag one edge", 32'(stat_out), 32'h0);
    step();
    check("R3 carry no overflow", 32'(stat_out), 32'(exp_stat(16'hFFFF, 16'h0001, 2'd0)));
    write_xy(16'h7FFF, 16'h0001);
    check("R1 sum", 32'(result), 32'h8000);
    step();
    check("R4 overflow no carry", 32'(stat_out), 32'h2);
    write_xy(16'h8000, 16'h8000);
    step();
    check("R4 carry and overflow", 32'(stat_out), 32'h3);
    check("R8 layout", 32'(stat_out), 32'(exp_stat(16'h8000, 16'h8000, 2'd0)));
  endtask

  task automatic t_logic();
    write_xy(16'hF0F0, 16'h3C3C);
    load_fn(2'd1);
    check("R2 and", 32'(result), 32'h3030);
    load_fn(2'd2);
    check("R2 xor", 32'(result), 32'hCCCC);
    load_fn(2'd3);
    check("R2 or", 32'(result), 32'hFCFC);
    check("R8 code field", 32'(stat_out), 32'(exp_stat(16'hF0F0, 16'h3C3C, 2'd3)));
  endtask

  task automatic t_flags_logic();
    load_fn(2'd1);
    write_xy(16'h8001, 16'h8001);
    check("R2 and result", 32'(result), 32'h8001);
    step();
    check("R3 R4 flags under and", 32'(stat_out), 32'h7);
  endtask

  task automatic t_skip();
    sk_req = 1; sk_query = 3'b010; #1;
    check("R5 carry query", 32'(skip_hit), 32'h1);
    sk_query = 3'b100; #1;
    check("R5 overflow query", 32'(skip_hit), 32'h1);
    sk_query = 3'b001; #1;
    check("R5 bit0 no effect", 32'(skip_hit), 32'h0);
    sk_req = 0; sk_query = 3'b110; #1;
    check("R5 no strobe", 32'(skip_hit), 32'h0);
    sk_query = 3'b000;
    write_xy(16'h0001, 16'h0002);
    step();
    sk_req = 1; sk_query = 3'b110; #1;
    check("R5 flags clear", 32'(skip_hit), 32'h0);
    sk_req = 0; sk_query = 3'b000;
  endtask

  task automatic t_status_wr();
    stat_wr = 1; stat_data = 16'hFFF3 & ~16'h000C | 16'h0008;
    step();
    stat_wr = 0;
    check("R6 stat write code", 32'(result), 32'h0003);
    step();
    check("R6 flag bits ignored", 32'(stat_out), 32'h0008);
    stat_wr = 1; stat_data = 16'h0004; fn_load = 1; fn_code = 2'd0;
    step();
    stat_wr = 0; fn_load = 0;
    check("R6 load wins", 32'(result), 32'h0003);
  endtask

  task automatic t_absent();
    x_wr = 1; x_data = 16'h00AA; #1;
    check("R9 illegal on write", 32'(a_illegal), 32'h1);
    check("R9 present no illegal", 32'(illegal_op), 32'h0);
    step();
    x_wr = 0; #1;
    check("R9 illegal idle", 32'(a_illegal), 32'h0);
    sk_req = 1; sk_query = 3'b110; #1;
    check("R9 illegal on query", 32'(a_illegal), 32'h1);
    check("R9 skip zero", 32'(a_skip), 32'h0);
    sk_req = 0; sk_query = 3'b000;
    fn_load = 1; fn_code = 2'd3; #1;
    check("R9 illegal on load", 32'(a_illegal), 32'h1);
    step();
    fn_load = 0;
    y_wr = 1; y_data = 16'h00FF;
    step();
    y_wr = 0;
    step();
    check("R9 result zero", 32'(a_result), 32'h0);
    check("R9 status zero", 32'(a_stat), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_add();
    t_logic();
    t_flags_logic();
    t_skip();
    t_status_wr();
    t_absent();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule